// File: doc/BRIEF.md
# Reset Cause Controller

This block merges every reset request in a chip into one system reset and keeps a record of what caused it. Six causes are handled: power-on, a low supply voltage, a watchdog timeout, loss of the reference clock, the external reset pin, and a wakeup that ends a low-leakage power mode. The analog supply comparator, the clock frequency monitor, the watchdog counter and the power-mode sequencer all sit outside. They reach the block only as digital levels and pulses.

The system reset output rises on the clock edge that samples any request. It stays high until 16 edges have passed with no request. A low-voltage reset holds the chip in reset until the supply-OK level comes back, even if software has cleared the enable in the meantime. A read-only cause register is reloaded at the start of each new reset. Requests that arrive while the reset is already active are added to it. A separate set of per-source wakeup flags is not cleared by resets. Software clears these flags itself by writing ones, and a power-on also clears them.

Top module: `reset_cause_unit`

## Requirements
- R1: While `por_n` is low, `sys_rst` is 1, `cause` is 6'b110000 and `wake_flags` is 0. `cause` bits are: [5] power-on, [4] low voltage, [3] watchdog, [2] clock loss, [1] pin, [0] wakeup. After `por_n` rises, `sys_rst` falls at the 16th rising clock edge.
- R2: `sys_rst` rises at the edge that samples a request and falls at the 16th edge after the last edge that sampled one.
- R3: A low supply (`supply_ok` = 0) causes a reset only while `lv_rst_en` is 1.
- R4: After a low-voltage reset, `sys_rst` stays high until `supply_ok` returns to 1, even if `lv_rst_en` is cleared first. `cause` then reads 6'b010000.
- R5: A `wdog_expire` pulse causes a reset with `cause` 6'b001000.
- R6: Clock loss causes a reset only when both `clkmon_en` and `clk_out_of_range` are 1. `cause` then reads 6'b000100.
- R7: The pin request passes through a two-stage synchroniser. With `low_power_active` at 0 it gives `cause` 6'b000010. With `low_power_active` at 1 it gives 6'b000011.
- R8: A `wake_event` bit causes a reset with `cause` 6'b000001 only while `low_power_active` is 1. Otherwise it is ignored: there is no reset and no flag is set.
- R9: `wake_flags[i]` is set by `wake_event[i]` while `low_power_active` is 1. It survives later system resets and is cleared only by writing 1 to `wake_flag_clr[i]` or by power-on.
- R10: A new reset clears the previous cause bits. Requests sampled on the same edge are all recorded. `cause` does not change while `sys_rst` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| supply_ok | input | 1 | Supply comparator level, 1 = above threshold |
| lv_rst_en | input | 1 | Enables reset on low supply |
| wdog_expire | input | 1 | Watchdog timeout request |
| clkmon_en | input | 1 | Enables the clock-loss reset |
| clk_out_of_range | input | 1 | Clock monitor out-of-range level |
| ext_rst_pin | input | 1 | External reset pin request, asynchronous, active high |
| low_power_active | input | 1 | Low-leakage power mode is active |
| wake_event | input | WAKE_W | Per-source wakeup requests |
| wake_flag_clr | input | WAKE_W | Write-one-to-clear for the wakeup flags |
| sys_rst | output | 1 | System reset, active high |
| cause | output | 6 | Cause of the most recent reset |
| wake_flags | output | WAKE_W | Retained wakeup source flags |

## Verification
Each source is applied on its own, and the recorded cause must name exactly that source and no stale bit. The gated sources (low voltage and clock loss) are also applied with their enable off, which separates a correct gate from a missing one. The pin is applied both inside and outside low-power mode, and a wake event is tried with low-power mode off, which shows whether the wakeup bit depends on the mode. A watchdog reset after a wakeup, together with a combined watchdog and clock-loss request, shows whether flags are kept across resets while the cause register is reloaded and merged.

// File: rtl/rcu_pkg.sv
package rcu_pkg;
    typedef struct packed {
        logic por;
        logic lvd;
        logic wdog;
        logic clkloss;
        logic pin;
        logic wakeup;
    } cause_t;

    localparam int CAUSE_W = $bits(cause_t);
endpackage

// File: rtl/rcu_sync.sv
module rcu_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rcu_hold_timer.sv
module rcu_hold_timer #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic active
);
    localparam int CW = $clog2(HOLD + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          act;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (req)                st_d.cnt = CW'(HOLD);
        else if (st_q.cnt != 0) st_d.cnt = st_q.cnt - 1'b1;
        st_d.act = (st_d.cnt != 0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= CW'(HOLD);
            st_q.act <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.act;
endmodule

// File: rtl/rcu_wake_flags.sv
module rcu_wake_flags #(
    parameter int WAKE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WAKE_W-1:0] events,
    input  logic              low_power,
    input  logic [WAKE_W-1:0] clr,
    output logic [WAKE_W-1:0] flags
);
    logic [WAKE_W-1:0] flags_d, flags_q;

    always_comb begin
        for (int i = 0; i < WAKE_W; i++) begin
            flags_d[i] = (flags_q[i] & ~clr[i]) | (events[i] & low_power);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/reset_cause_unit.sv
module reset_cause_unit
    import rcu_pkg::*;
#(
    parameter int WAKE_W      = 4,
    parameter int HOLD_CYCLES = 16,
    parameter int PIN_SYNC    = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              supply_ok,
    input  logic              lv_rst_en,
    input  logic              wdog_expire,
    input  logic              clkmon_en,
    input  logic              clk_out_of_range,
    input  logic              ext_rst_pin,
    input  logic              low_power_active,
    input  logic [WAKE_W-1:0] wake_event,
    input  logic [WAKE_W-1:0] wake_flag_clr,
    output logic              sys_rst,
    output logic [CAUSE_W-1:0] cause,
    output logic [WAKE_W-1:0] wake_flags
);
    typedef struct packed {
        cause_t cause;
        logic   lv_hold;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    pin_s;
    logic    rst_active;
    logic    lvd_now, lvd_req, wdog_req, clk_req, wake_req, any_req;
    cause_t  req_bits;

    rcu_sync #(.STAGES(PIN_SYNC)) u_pin_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d     (ext_rst_pin),
        .q     (pin_s)
    );

    always_comb begin
        lvd_now  = lv_rst_en & ~supply_ok;
        lvd_req  = lvd_now | st_q.lv_hold;
        wdog_req = wdog_expire;
        clk_req  = clkmon_en & clk_out_of_range;
        wake_req = low_power_active & (|wake_event);
        any_req  = lvd_req | wdog_req | clk_req | pin_s | wake_req;

        req_bits.por     = 1'b0;
        req_bits.lvd     = lvd_req;
        req_bits.wdog    = wdog_req;
        req_bits.clkloss = clk_req;
        req_bits.pin     = pin_s;
        req_bits.wakeup  = low_power_active;

        st_d = st_q;
        if (lvd_now)         st_d.lv_hold = 1'b1;
        else if (supply_ok)  st_d.lv_hold = 1'b0;

        if (any_req) begin
            if (!rst_active) st_d.cause = req_bits;
            else             st_d.cause = st_q.cause | req_bits;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.cause         <= '0;
            st_q.cause.por     <= 1'b1;
            st_q.cause.lvd     <= 1'b1;
            st_q.lv_hold       <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    rcu_hold_timer #(.HOLD(HOLD_CYCLES)) u_hold (
        .clk    (clk),
        .rst_n  (por_n),
        .req    (any_req),
        .active (rst_active)
    );

    rcu_wake_flags #(.WAKE_W(WAKE_W)) u_wake (
        .clk       (clk),
        .rst_n     (por_n),
        .events    (wake_event),
        .low_power (low_power_active),
        .clr       (wake_flag_clr),
        .flags     (wake_flags)
    );

    assign sys_rst = rst_active;
    assign cause   = st_q.cause;
endmodule

// File: rtl/rcu_checker.sv
module rcu_checker #(
    parameter int WAKE_W = 4
) (
    input logic              clk,
    input logic              por_n,
    input logic              supply_ok,
    input logic              lv_rst_en,
    input logic              wdog_expire,
    input logic              clkmon_en,
    input logic              clk_out_of_range,
    input logic [WAKE_W-1:0] wake_flag_clr,
    input logic              sys_rst,
    input logic [5:0]        cause,
    input logic [WAKE_W-1:0] wake_flags
);
    // R5
    wdog_forces_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
        wdog_expire |=> sys_rst);

    // R6
    clkloss_forces_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
        (clkmon_en && clk_out_of_range) |=> sys_rst);

    // R3
    low_supply_forces_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
        (lv_rst_en && !supply_ok) |=> sys_rst);

    // R10
    cause_stable_when_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst |-> $stable(cause));

    // R9
    flags_kept_at_release_chk: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(sys_rst) && $past(wake_flag_clr) == '0) |-> $stable(wake_flags));
endmodule

bind reset_cause_unit rcu_checker #(.WAKE_W(WAKE_W)) u_rcu_chk (
    .clk              (clk),
    .por_n            (por_n),
    .supply_ok        (supply_ok),
    .lv_rst_en        (lv_rst_en),
    .wdog_expire      (wdog_expire),
    .clkmon_en        (clkmon_en),
    .clk_out_of_range (clk_out_of_range),
    .wake_flag_clr    (wake_flag_clr),
    .sys_rst          (sys_rst),
    .cause            (cause),
    .wake_flags       (wake_flags)
);

// File: tb/tb_reset_cause_unit.sv
module tb_reset_cause_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WAKE_W     = 4;

    logic              clk = 1'b0;
    logic              por_n, supply_ok, lv_rst_en, wdog_expire;
    logic              clkmon_en, clk_out_of_range, ext_rst_pin, low_power_active;
    logic [WAKE_W-1:0] wake_event, wake_flag_clr;
    logic              sys_rst;
    logic [5:0]        cause;
    logic [WAKE_W-1:0] wake_flags;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [5:0] exp_q[$];
    string      tag_q[$];
    logic       prev_rst = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    reset_cause_unit #(.WAKE_W(WAKE_W)) dut (
        .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .lv_rst_en(lv_rst_en),
        .wdog_expire(wdog_expire), .clkmon_en(clkmon_en),
        .clk_out_of_range(clk_out_of_range), .ext_rst_pin(ext_rst_pin),
        .low_power_active(low_power_active), .wake_event(wake_event),
        .wake_flag_clr(wake_flag_clr), .sys_rst(sys_rst), .cause(cause),
        .wake_flags(wake_flags)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic expect_cause(logic [5:0] exp, string req);
        exp_q.push_back(exp);
        tag_q.push_back(req);
    endtask

    task automatic wait_release();
        while (sys_rst === 1'b1) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: on each reset release compare the recorded cause with the queue
    always @(negedge clk) begin
        if (por_n === 1'b1 && prev_rst === 1'b1 && sys_rst === 1'b0) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected release", 8'(cause), 8'hFF);
            end else begin
                automatic logic [5:0] e = exp_q.pop_front();
                automatic string      t = tag_q.pop_front();
                check(t, 8'(cause), 8'(e));
            end
        end
        prev_rst <= sys_rst;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        por_n = 1'b0; supply_ok = 1'b1; lv_rst_en = 1'b0; wdog_expire = 1'b0;
        clkmon_en = 1'b0; clk_out_of_range = 1'b0; ext_rst_pin = 1'b0;
        low_power_active = 1'b0; wake_event = '0; wake_flag_clr = '0;
        repeat (3) @(negedge clk);
        check("R1 reset sys_rst", 8'(sys_rst), 8'd1);
        check("R1 reset cause", 8'(cause), 8'b110000);
        check("R1 reset wake_flags", 8'(wake_flags), 8'd0);

        expect_cause(6'b110000, "R1 power-on cause");
        por_n = 1'b1;
        repeat (15) @(negedge clk);
        check("R1 held through 15 edges", 8'(sys_rst), 8'd1);
        @(negedge clk);
        check("R1 released at 16th edge", 8'(sys_rst), 8'd0);
        @(negedge clk);

        // R5 and R2: watchdog pulse, exact hold length
        expect_cause(6'b001000, "R5 watchdog cause");
        wdog_expire = 1'b1;
        @(negedge clk);
        wdog_expire = 1'b0;
        check("R5 reset asserted", 8'(sys_rst), 8'd1);
        repeat (15) @(negedge clk);
        check("R2 held 15 edges after request", 8'(sys_rst), 8'd1);
        @(negedge clk);
        check("R2 released at 16th edge", 8'(sys_rst), 8'd0);
        @(negedge clk);

        // R3: low supply with enable off is ignored
        supply_ok = 1'b0;
        repeat (30) @(negedge clk);
        check("R3 no reset when disabled", 8'(sys_rst), 8'd0);
        supply_ok = 1'b1;
        repeat (2) @(negedge clk);

        // R4: low-voltage reset held until supply returns
        expect_cause(6'b010000, "R4 low-voltage cause");
        lv_rst_en = 1'b1; supply_ok = 1'b0;
        repeat (5) @(negedge clk);
        lv_rst_en = 1'b0;
        repeat (40) @(negedge clk);
        check("R4 held while supply low", 8'(sys_rst), 8'd1);
        supply_ok = 1'b1;
        wait_release();

        // R6: clock loss gated by enable
        clk_out_of_range = 1'b1;
        repeat (30) @(negedge clk);
        check("R6 no reset when monitor off", 8'(sys_rst), 8'd0);
        expect_cause(6'b000100, "R6 clock-loss cause");
        clkmon_en = 1'b1;
        @(negedge clk);
        clkmon_en = 1'b0; clk_out_of_range = 1'b0;
        wait_release();

        // R7: pin outside and inside low-power mode
        expect_cause(6'b000010, "R7 pin cause");
        ext_rst_pin = 1'b1;
        repeat (3) @(negedge clk);
        ext_rst_pin = 1'b0;
        wait_release();
        low_power_active = 1'b1;
        expect_cause(6'b000011, "R7 pin exit from low power");
        ext_rst_pin = 1'b1;
        repeat (3) @(negedge clk);
        ext_rst_pin = 1'b0;
        wait_release();
        low_power_active = 1'b0;
        @(negedge clk);

        // R8: wake event ignored outside low power
        wake_event = 4'b0001;
        repeat (5) @(negedge clk);
        wake_event = '0;
        @(negedge clk);
        check("R8 no reset without low power", 8'(sys_rst), 8'd0);
        check("R8 no flag without low power", 8'(wake_flags), 8'd0);

        // R8, R9: wake event in low power
        low_power_active = 1'b1;
        expect_cause(6'b000001, "R8 wakeup cause");
        wake_event = 4'b0100;
        @(negedge clk);
        wake_event = '0; low_power_active = 1'b0;
        wait_release();
        check("R9 flag set by wake", 8'(wake_flags), 8'b0100);

        // R9, R10: flags survive a later reset, cause replaced
        expect_cause(6'b001000, "R10 old cause cleared");
        wdog_expire = 1'b1;
        @(negedge clk);
        wdog_expire = 1'b0;
        wait_release();
        check("R9 flag kept across reset", 8'(wake_flags), 8'b0100);
        wake_flag_clr = 4'b0100;
        @(negedge clk);
        wake_flag_clr = '0;
        @(negedge clk);
        check("R9 flag cleared by write", 8'(wake_flags), 8'd0);

        // R10: simultaneous requests
        expect_cause(6'b001100, "R10 combined cause");
        wdog_expire = 1'b1; clkmon_en = 1'b1; clk_out_of_range = 1'b1;
        @(negedge clk);
        wdog_expire = 1'b0; clkmon_en = 1'b0; clk_out_of_range = 1'b0;
        wait_release();
        repeat (20) @(negedge clk);
        check("R10 cause stable while idle", 8'(cause), 8'b001100);
        check("R10 all releases matched", 8'(exp_q.size()), 8'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule